// File: doc/BRIEF.md
# Graphic LCD power-up and power-down sequencer

This block brings a graphic LCD controller up and takes it down again. On a power-up request it can first pulse an active-high panel reset and wait for the panel to settle. It then hands a fixed series of 8-bit instructions, one at a time, to a serial framer. After the framer accepts each instruction, the block waits the minimum execution time of that instruction before it offers the next one. A power-down request runs a shorter series with no reset pulse. Every wait is a whole number of clock cycles derived from the `CLK_HZ` parameter, always rounded up.

The framer handshake is simple. The block holds `cmd_valid` high with a steady `cmd_byte` until the framer raises `cmd_ack` for one cycle. The framer may raise `cmd_err` in that same cycle, which cuts the sequence short and sets a sticky error flag. Requests are latched as pending bits. A request that arrives during a running sequence is served after that sequence ends.

The controller has six states:
- IDLE: waits for a pending request.
- RST_HOLD: drives the panel reset.
- RST_WAIT: the settling delay after reset.
- ISSUE: offers an instruction.
- WAIT: the execution delay after an instruction.
- FINISH: a one-cycle completion state.

The transitions are:
- IDLE goes to ISSUE for power-down. It also goes to ISSUE for power-up when no reset line is fitted.
- IDLE goes to RST_HOLD for power-up when a reset line is fitted.
- RST_HOLD goes to RST_WAIT when the hold time expires.
- RST_WAIT goes to ISSUE when the settle time expires.
- ISSUE goes to WAIT on a clean acknowledge, and to FINISH on an acknowledge that carries an error.
- WAIT goes to ISSUE when the delay expires and more instructions remain, and to FINISH after the last one.
- FINISH goes to IDLE.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `cmd_valid`, `panel_rst`, `busy`, `done` and `err` are all 0. Reset is the only thing that clears `err`.
- R2: With `panel_rst_en`=1, a power-up drives `panel_rst` high for exactly ceil(15 µs·CLK_HZ) cycles. After `panel_rst` falls, `cmd_valid` stays low for exactly ceil(40 ms·CLK_HZ) cycles, then the first instruction is offered.
- R3: With `panel_rst_en`=0, a power-up never raises `panel_rst`. The first instruction is offered in the cycle after the one in which the request was taken from pending.
- R4: A power-up offers the instruction bytes 0x30, 0x0C, 0x36 and 0x01, in that order.
- R5: A power-down offers the instruction bytes 0x01 and then 0x08, and never pulses `panel_rst`.
- R6: After the clock edge where a clean `cmd_ack` is sampled, the block waits before it raises `cmd_valid` again or raises `done`. The wait is exactly ceil(1600 µs·CLK_HZ) cycles when the byte was 0x01, and ceil(72 µs·CLK_HZ) cycles for any other byte.
- R7: While `cmd_valid` is high and `cmd_ack` is low, `cmd_valid` stays high and `cmd_byte` does not change.
- R8: If `cmd_err` is high in the acknowledge cycle, no further instruction of that sequence is offered. `done` rises in the next cycle, and `err` goes to 1 and stays 1 until reset.
- R9: A request that arrives while `busy` is high is held. Its sequence starts after the running one completes.
- R10: When power-up and power-down are both pending, the power-down sequence runs first and the power-up sequence follows.
- R11: `done` is a one-cycle pulse, during which `busy` is still 1. `busy` is 0 in the following cycle unless another request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| panel_rst_en | input | 1 | 1 when a panel reset line is fitted; only changed while idle |
| req_on | input | 1 | Power-up request pulse |
| req_off | input | 1 | Power-down request pulse |
| cmd_valid | output | 1 | An instruction is offered to the framer |
| cmd_byte | output | 8 | Offered instruction byte |
| cmd_ack | input | 1 | Framer has taken the offered instruction |
| cmd_err | input | 1 | Framer reports a failure with this acknowledge |
| panel_rst | output | 1 | Active-high panel reset |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | Sticky error flag |

## Verification
The bench builds the design with a 100 kHz clock parameter, so a 72 µs wait of 7.2 cycles must round up to 8. A design that truncated would show a gap one cycle too short.

The bench drives an error at every instruction position of both sequences. A design that let one more instruction through, or that still ran the post-instruction wait, would show an extra byte or a late `done`.

It also covers the following cases:
- A request that arrives in the middle of a sequence must be served afterwards. A design that dropped it would never start the second sequence.
- Simultaneous requests must run power-down first. Reversing the priority would show the wrong first byte.
- The framer's acknowledge is delayed by zero to three cycles, to catch a `cmd_byte` that changes before it is accepted.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST_HOLD,
        S_RST_WAIT,
        S_ISSUE,
        S_WAIT,
        S_FINISH
    } seq_state_e;

    localparam logic [7:0] OP_BASIC    = 8'h30;
    localparam logic [7:0] OP_DISP_ON  = 8'h0C;
    localparam logic [7:0] OP_GFX_ON   = 8'h36;
    localparam logic [7:0] OP_CLEAR    = 8'h01;
    localparam logic [7:0] OP_DISP_OFF = 8'h08;

    // Instruction at position idx of the power-up (off=0) or power-down (off=1) series
    function automatic logic [7:0] seq_cmd(input logic off, input logic [1:0] idx);
        logic [7:0] c;
        if (off) begin
            c = (idx == 2'd0) ? OP_CLEAR : OP_DISP_OFF;
        end else begin
            case (idx)
                2'd0:    c = OP_BASIC;
                2'd1:    c = OP_DISP_ON;
                2'd2:    c = OP_GFX_ON;
                default: c = OP_CLEAR;
            endcase
        end
        return c;
    endfunction

    function automatic logic seq_last(input logic off, input logic [1:0] idx);
        return off ? (idx == 2'd1) : (idx == 2'd3);
    endfunction

endpackage

// File: rtl/lcdseq_timer.sv
module lcdseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // A countdown in progress only moves down by one per cycle
    assert_timer_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lcdseq_req_latch.sv
module lcdseq_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_on,
    input  logic req_off,
    input  logic take_on,
    input  logic take_off,
    output logic pend_on,
    output logic pend_off
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_on  <= 1'b0;
            pend_off <= 1'b0;
        end else begin
            pend_on  <= req_on  | (pend_on  & ~take_on);
            pend_off <= req_off | (pend_off & ~take_off);
        end
    end

    // R9: a request is never lost unless it was just taken
    assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_on && !take_on) |=> pend_on);
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       panel_rst_en,
    input  logic       req_on,
    input  logic       req_off,
    output logic       cmd_valid,
    output logic [7:0] cmd_byte,
    input  logic       cmd_ack,
    input  logic       cmd_err,
    output logic       panel_rst,
    output logic       busy,
    output logic       done,
    output logic       err
);
    import lcdseq_pkg::*;

    localparam longint unsigned HZ      = longint'(CLK_HZ);
    localparam longint unsigned US_DIV  = 64'd1_000_000;
    localparam longint unsigned T_RST   = (64'd15    * HZ + US_DIV - 1) / US_DIV;
    localparam longint unsigned T_SETL  = (64'd40000 * HZ + US_DIV - 1) / US_DIV;
    localparam longint unsigned T_SHORT = (64'd72    * HZ + US_DIV - 1) / US_DIV;
    localparam longint unsigned T_CLR   = (64'd1600  * HZ + US_DIV - 1) / US_DIV;
    localparam longint unsigned T_M1    = (T_RST > T_SHORT) ? T_RST : T_SHORT;
    localparam longint unsigned T_M2    = (T_SETL > T_CLR) ? T_SETL : T_CLR;
    localparam longint unsigned T_MAX   = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int              CW      = $clog2(T_MAX + 1);
    localparam logic [CW-1:0]   L_RST   = CW'(T_RST - 1);
    localparam logic [CW-1:0]   L_SETL  = CW'(T_SETL - 1);
    localparam logic [CW-1:0]   L_SHORT = CW'(T_SHORT - 1);
    localparam logic [CW-1:0]   L_CLR   = CW'(T_CLR - 1);

    seq_state_e    state_q, state_d;
    logic [1:0]    step_q, step_d;
    logic          off_q, off_d;
    logic          err_q, err_d;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          tmr_zero;
    logic          take_on, take_off, pend_on, pend_off;
    logic [7:0]    cur_cmd;

    assign cur_cmd = seq_cmd(off_q, step_q);

    lcdseq_req_latch u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_on   (req_on),
        .req_off  (req_off),
        .take_on  (take_on),
        .take_off (take_off),
        .pend_on  (pend_on),
        .pend_off (pend_off)
    );

    lcdseq_timer #(.W(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .zero     (tmr_zero)
    );

    // Next-state and sequencing decisions
    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        off_d    = off_q;
        err_d    = err_q;
        ld       = 1'b0;
        ld_val   = '0;
        take_on  = 1'b0;
        take_off = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (pend_off) begin
                    take_off = 1'b1;
                    off_d    = 1'b1;
                    step_d   = 2'd0;
                    state_d  = S_ISSUE;
                end else if (pend_on) begin
                    take_on = 1'b1;
                    off_d   = 1'b0;
                    step_d  = 2'd0;
                    if (panel_rst_en) begin
                        ld      = 1'b1;
                        ld_val  = L_RST;
                        state_d = S_RST_HOLD;
                    end else begin
                        state_d = S_ISSUE;
                    end
                end
            end
            S_RST_HOLD: begin
                if (tmr_zero) begin
                    ld      = 1'b1;
                    ld_val  = L_SETL;
                    state_d = S_RST_WAIT;
                end
            end
            S_RST_WAIT: begin
                if (tmr_zero) state_d = S_ISSUE;
            end
            S_ISSUE: begin
                if (cmd_ack) begin
                    if (cmd_err) begin
                        err_d   = 1'b1;
                        state_d = S_FINISH;
                    end else begin
                        ld      = 1'b1;
                        ld_val  = (cur_cmd == OP_CLEAR) ? L_CLR : L_SHORT;
                        state_d = S_WAIT;
                    end
                end
            end
            S_WAIT: begin
                if (tmr_zero) begin
                    if (seq_last(off_q, step_q)) begin
                        state_d = S_FINISH;
                    end else begin
                        step_d  = step_q + 2'd1;
                        state_d = S_ISSUE;
                    end
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= 2'd0;
            off_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            off_q   <= off_d;
            err_q   <= err_d;
        end
    end

    // Outputs decoded from state
    always_comb begin
        cmd_valid = (state_q == S_ISSUE);
        cmd_byte  = (state_q == S_ISSUE) ? cur_cmd : 8'h00;
        panel_rst = (state_q == S_RST_HOLD);
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        err       = err_q;
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_byte)));

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ack && cmd_err) |=> (done && !cmd_valid));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ack && !cmd_err) |=> (!cmd_valid && !done));

    assert_noline_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && pend_on && !pend_off && !panel_rst_en) |=> !panel_rst);

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: tb/tb_lcd_pwr_seq.sv
module tb_lcd_pwr_seq;
    localparam int unsigned HZ = 100_000;

    function automatic int cyc_of(input int us);
        return int'((longint'(us) * longint'(HZ) + 64'd999_999) / 64'd1_000_000);
    endfunction

    localparam int T_RST   = 2;     // ceil(15 us * 100 kHz)
    localparam int T_SETL  = 4000;  // 40 ms
    localparam int T_SHORT = 8;     // 7.2 rounded up
    localparam int T_CLR   = 160;   // 1600 us

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       panel_rst_en = 1'b0, req_on = 1'b0, req_off = 1'b0;
    logic       cmd_ack = 1'b0, cmd_err = 1'b0;
    logic       cmd_valid, panel_rst, busy, done, err;
    logic [7:0] cmd_byte;

    int  n_cmp = 0, n_bad = 0, cyc = 0;
    bit  err_exp = 1'b0;

    always #2 clk = ~clk;

    lcd_pwr_seq #(.CLK_HZ(HZ)) dut (
        .clk(clk), .rst_n(rst_n), .panel_rst_en(panel_rst_en),
        .req_on(req_on), .req_off(req_off),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cmd_ack(cmd_ack), .cmd_err(cmd_err),
        .panel_rst(panel_rst), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input bit off, input int i);
        if (off) return (i == 0) ? 8'h01 : 8'h08;
        case (i)
            0:       return 8'h30;
            1:       return 8'h0C;
            2:       return 8'h36;
            default: return 8'h01;
        endcase
    endfunction

    function automatic int exp_wait(input logic [7:0] b);
        return (b == 8'h01) ? cyc_of(1600) : cyc_of(72);
    endfunction

    // pulse: bit0 = req_on, bit1 = req_off, 0 = sequence already pending
    // mid: 1/2 = pulse req_on/req_off together with the first acknowledge
    task automatic do_seq(input bit off, input bit rl, input int pulse, input int err_step,
                          input int dly, input int mid, input bit chk_idle, output int got);
        int len, ncmd, gap, rst_hi, guard, expg;
        logic [7:0] last;
        len = off ? 2 : 4; ncmd = 0; gap = 0; rst_hi = 0; guard = 0; last = 8'h00;
        if (pulse != 0) begin
            panel_rst_en = rl;
            req_on = pulse[0]; req_off = pulse[1];
            @(negedge clk);
            req_on = 1'b0; req_off = 1'b0;
        end else begin
            @(negedge clk);
        end
        while (!done && guard < 20000) begin
            guard++;
            if (panel_rst) begin
                rst_hi++; gap = 0;
            end else if (cmd_valid) begin
                expg = (ncmd == 0) ? ((rl && !off) ? T_SETL : 1) : exp_wait(last);
                chk(gap == expg, (ncmd == 0) ? ((rl && !off) ? "R2 settle" : "R3 start") : "R6 wait",
                    gap, expg);
                chk(ncmd < len && cmd_byte == exp_cmd(off, ncmd), off ? "R5 byte" : "R4 byte",
                    cmd_byte, exp_cmd(off, ncmd));
                last = cmd_byte;
                for (int k = 0; k < dly; k++) begin
                    @(negedge clk);
                    chk(cmd_valid && cmd_byte == last, "R7 hold", cmd_byte, last);
                end
                cmd_ack = 1'b1;
                cmd_err = (ncmd == err_step);
                if (ncmd == 0 && mid == 1) req_on = 1'b1;
                if (ncmd == 0 && mid == 2) req_off = 1'b1;
                @(negedge clk);
                cmd_ack = 1'b0; cmd_err = 1'b0; req_on = 1'b0; req_off = 1'b0;
                if (ncmd == err_step) err_exp = 1'b1;
                ncmd++; gap = 0;
                continue;
            end else begin
                gap++;
            end
            @(negedge clk);
        end
        chk(rst_hi == ((rl && !off) ? T_RST : 0), (rl && !off) ? "R2 pulse" : "R3/R5 no pulse",
            rst_hi, (rl && !off) ? T_RST : 0);
        if (err_step >= 0 && err_step < len) begin
            chk(ncmd == err_step + 1, "R8 abort count", ncmd, err_step + 1);
            chk(gap == 0, "R8 abort done", gap, 0);
        end else begin
            chk(ncmd == len, off ? "R5 count" : "R4 count", ncmd, len);
            chk(gap == exp_wait(last), "R6 last wait", gap, exp_wait(last));
        end
        chk(done && busy, "R11 done", {done, busy}, 3);
        chk(err == err_exp, "R8 err flag", err, err_exp);
        if (chk_idle) begin
            @(negedge clk);
            chk(!done && !busy, "R11 idle", {done, busy}, 0);
        end
        got = ncmd;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog all actual=%0d expected=%0d", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int g, g2;
        chk(cyc_of(15) == T_RST && cyc_of(40000) == T_SETL && cyc_of(72) == T_SHORT
            && cyc_of(1600) == T_CLR, "R6 rounding", cyc_of(72), T_SHORT);
        repeat (4) @(negedge clk);
        chk({cmd_valid, panel_rst, busy, done, err} == 5'b0, "R1 in reset",
            {cmd_valid, panel_rst, busy, done, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({cmd_valid, panel_rst, busy, done, err} == 5'b0, "R1 after reset",
            {cmd_valid, panel_rst, busy, done, err}, 0);

        do_seq(1'b0, 1'b1, 1, -1, 0, 0, 1'b1, g);           // R2 R4 with reset line
        do_seq(1'b1, 1'b1, 2, -1, 0, 0, 1'b1, g);           // R5
        for (int d = 0; d < 4; d++) do_seq(1'b0, 1'b0, 1, -1, d, 0, 1'b1, g);   // R7 sweep
        for (int e = 0; e < 4; e++) do_seq(1'b0, 1'b0, 1, e, 1, 0, 1'b1, g);    // R8 up
        for (int e = 0; e < 2; e++) do_seq(1'b1, 1'b0, 2, e, 0, 0, 1'b1, g);    // R8 down
        do_seq(1'b0, 1'b0, 1, -1, 0, 0, 1'b1, g);           // R8 sticky over a clean run

        do_seq(1'b0, 1'b0, 1, -1, 0, 2, 1'b0, g);           // R9 off requested during on
        do_seq(1'b1, 1'b0, 0, -1, 0, 0, 1'b1, g2);
        chk(g2 == 2, "R9 pending off ran", g2, 2);
        do_seq(1'b1, 1'b0, 2, -1, 0, 1, 1'b0, g);           // R9 on requested during off
        do_seq(1'b0, 1'b0, 0, -1, 2, 0, 1'b1, g2);
        chk(g2 == 4, "R9 pending on ran", g2, 4);

        do_seq(1'b1, 1'b0, 3, -1, 0, 0, 1'b0, g);           // R10 both at once
        chk(g == 2, "R10 off first", g, 2);
        do_seq(1'b0, 1'b0, 0, -1, 0, 0, 1'b1, g2);
        chk(g2 == 4, "R10 on second", g2, 4);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        err_exp = 1'b0;
        @(negedge clk);
        chk(!err && !busy, "R1 reset clears err", err, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule